// File: doc/BRIEF.md
# Virtual-Lane Block Distributor with Alignment Markers

This block spreads a single stream of scrambled 66-bit blocks over a set of parallel virtual lanes. Successive input blocks are dealt to lane 0, lane 1 and so on up to the last lane, and then the deal starts again at lane 0. Once a full round has been collected, all lanes are presented together for one cycle with a shared valid strobe. The lane count is a parameter. Use 4 for a 40G link. Use 20 for a 100G link, because 20 is the least common multiple of 10 and 4, so it divides evenly over either physical lane count.

At a fixed period the block launches a marker round. In that round every lane carries an alignment block that identifies the lane, and all lanes carry it in the same cycle. A receiver uses these blocks to find each lane, deskew the lanes and put them back in order. Markers are placed purely by count. They pay no attention to packet boundaries, so a marker can land in the middle of a packet payload. While a marker round is being launched, the input is stalled so that no data block is dropped.

Top module: `vlane_distributor`

## Requirements
- R1: Each round takes NUM_LANES accepted blocks. The k-th block of a round is placed on lane k. Lane i occupies bits [66*i+65 : 66*i] of `lane_blk`.
- R2: `lane_valid` is high for exactly one cycle, and that cycle is the one after the block that completes a data round is accepted. All lanes are updated in that same cycle.
- R3: A marker block has bits [1:0] = 2'b10 (control header), bits [9:2] = 8'h5A, bits [17:10] = the lane index, bits [25:18] = the bitwise complement of the lane index, and zeros in all other bits.
- R4: Between two consecutive marker rounds there are exactly MARK_PERIOD-1 data rounds. This spacing depends only on the block count and not on block contents, so a marker can fall inside a packet.
- R5: `in_ready` is low only in a cycle that precedes a marker round, and it is low in every such cycle. A block offered while `in_ready` is low is not taken and is not lost. It is delivered once it is accepted later.
- R6: While reset is asserted, `lane_valid` and `in_ready` are both low. The first clock edge after reset is released emits a marker round.
- R7: The same RTL works at NUM_LANES = 4 and NUM_LANES = 20, and every lane's marker carries its own distinct index.
- R8: An unfinished round is held for as long as necessary across idle input cycles. No output is produced until the round's last block arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_blk | input | 66 | Incoming scrambled block, sync header in bits [1:0] |
| in_valid | input | 1 | `in_blk` holds a block |
| in_ready | output | 1 | Block accepted on this edge when `in_valid` is also high |
| lane_blk | output | 66*NUM_LANES | One block per virtual lane, lane 0 in the low bits |
| lane_valid | output | 1 | All lanes carry a new block this cycle |

## Verification
The hazardous coincidence is a data round completing on the same edge that the period count expires. The marker round must then follow directly, and the input must stall for exactly that one cycle. The bench makes this happen by streaming data back to back with a short period. It also holds `in_valid` high through every stall. The scoreboard therefore expects a marker immediately after every (period-1)-th data round, and it expects each stalled block to show up intact in the next round. A separate per-cycle check ties every low `in_ready` to the marker round that appears on the next cycle.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    localparam int unsigned BLK_W    = 66;
    localparam logic [1:0]  HDR_CTRL = 2'b10;
    localparam logic [7:0]  MARK_TAG = 8'h5A;

    // Alignment block for one lane: control header, tag byte, index, ~index
    function automatic logic [BLK_W-1:0] marker_blk(input int unsigned idx);
        logic [BLK_W-1:0] m;
        logic [7:0]       id8;
        id8      = idx[7:0];
        m        = '0;
        m[1:0]   = HDR_CTRL;
        m[9:2]   = MARK_TAG;
        m[17:10] = id8;
        m[25:18] = ~id8;
        return m;
    endfunction

endpackage

// File: rtl/vlane_marker_gen.sv
module vlane_marker_gen
    import vlane_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4
) (
    output logic [NUM_LANES*BLK_W-1:0] markers
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign markers[g*BLK_W +: BLK_W] = marker_blk(g);
    end

endmodule

// File: rtl/vlane_period_timer.sv
module vlane_period_timer #(
    parameter int unsigned MARK_PERIOD = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic round_done,
    input  logic marker_sent,
    output logic mark_pend
);

    localparam int unsigned CNT_W = (MARK_PERIOD > 2) ? $clog2(MARK_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MARK_PERIOD - 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (marker_sent) begin
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end else if (round_done) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.pend = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mark_pend = st_q.pend;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT); // R4
    AST_NO_ROUND_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> !round_done); // R5
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && marker_sent) |=> !st_q.pend); // R4

endmodule

// File: rtl/vlane_rr_dealer.sv
module vlane_rr_dealer
    import vlane_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept,
    input  logic [BLK_W-1:0]             blk_in,
    output logic                         round_done,
    output logic [NUM_LANES*BLK_W-1:0]   row_out
);

    localparam int unsigned PTR_W = $clog2(NUM_LANES);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_LANES - 1);

    typedef struct packed {
        logic [PTR_W-1:0]                ptr;
        logic [NUM_LANES-1:0][BLK_W-1:0] hold;
    } deal_t;

    deal_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.hold[st_q.ptr] = blk_in;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.hold <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign round_done = accept && (st_q.ptr == LAST);

    // Lanes below the last come from the hold slots, the last lane from the input
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_row
        if (g == NUM_LANES - 1) begin : g_tail
            assign row_out[g*BLK_W +: BLK_W] = blk_in;
        end else begin : g_held
            assign row_out[g*BLK_W +: BLK_W] = st_q.hold[g];
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q.ptr == (($past(st_q.ptr) == LAST) ? '0 : PTR_W'($past(st_q.ptr) + 1'b1))); // R1
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(st_q.ptr)); // R8

endmodule

// File: rtl/vlane_distributor.sv
module vlane_distributor
    import vlane_pkg::*;
#(
    parameter int unsigned NUM_LANES   = 4,
    parameter int unsigned MARK_PERIOD = 16384
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [65:0]                 in_blk,
    input  logic                        in_valid,
    output logic                        in_ready,
    output logic [NUM_LANES*66-1:0]     lane_blk,
    output logic                        lane_valid
);

    localparam int unsigned LANES_W = NUM_LANES * BLK_W;

    typedef struct packed {
        logic [LANES_W-1:0] lanes;
        logic               valid;
        logic               mark;
    } out_t;

    out_t st_d, st_q;

    logic               mark_pend;
    logic               accept;
    logic               round_done;
    logic [LANES_W-1:0] row;
    logic [LANES_W-1:0] markers;

    assign in_ready = !mark_pend;
    assign accept   = in_valid && in_ready;

    vlane_rr_dealer #(.NUM_LANES(NUM_LANES)) u_dealer (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .blk_in     (in_blk),
        .round_done (round_done),
        .row_out    (row)
    );

    vlane_period_timer #(.MARK_PERIOD(MARK_PERIOD)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .round_done  (round_done),
        .marker_sent (mark_pend),
        .mark_pend   (mark_pend)
    );

    vlane_marker_gen #(.NUM_LANES(NUM_LANES)) u_mgen (
        .markers (markers)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.mark  = 1'b0;
        if (mark_pend) begin
            st_d.lanes = markers;
            st_d.valid = 1'b1;
            st_d.mark  = 1'b1;
        end else if (round_done) begin
            st_d.lanes = row;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lanes <= '0;
            st_q.valid <= 1'b0;
            st_q.mark  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_blk   = st_q.lanes;
    assign lane_valid = st_q.valid;

    AST_MARK_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mark |-> $past(!in_ready)); // R5
    AST_FULL_ROUND_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        round_done |=> (lane_valid && !st_q.mark)); // R2
    AST_ACCEPT_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !st_q.mark); // R5
    AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mark |-> lane_valid); // R3

endmodule

// File: tb/tb_vlane_distributor.sv
module tb_vlane_distributor;

    localparam int N   = 4;
    localparam int NW  = 20;
    localparam int PER = 3;
    localparam int W   = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0]    in_blk = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [N*W-1:0]  lane_blk;
    logic            lane_valid;

    logic [W-1:0]    w_in_blk = '0;
    logic            w_in_valid = 1'b0;
    logic            w_in_ready;
    logic [NW*W-1:0] w_lane_blk;
    logic            w_lane_valid;

    int checks = 0;
    int fails  = 0;

    vlane_distributor #(.NUM_LANES(N), .MARK_PERIOD(PER)) dut (
        .clk(clk), .rst_n(rst_n), .in_blk(in_blk), .in_valid(in_valid),
        .in_ready(in_ready), .lane_blk(lane_blk), .lane_valid(lane_valid)
    );

    vlane_distributor #(.NUM_LANES(NW), .MARK_PERIOD(PER)) dut_w (
        .clk(clk), .rst_n(rst_n), .in_blk(w_in_blk), .in_valid(w_in_valid),
        .in_ready(w_in_ready), .lane_blk(w_lane_blk), .lane_valid(w_lane_valid)
    );

    function automatic logic [W-1:0] exp_marker(input int idx);
        logic [W-1:0] m;
        logic [7:0]   i8;
        i8       = idx[7:0];
        m        = '0;
        m[1:0]   = 2'b10;
        m[9:2]   = 8'h5A;
        m[17:10] = i8;
        m[25:18] = ~i8;
        return m;
    endfunction

    function automatic logic [N*W-1:0] marker_row();
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = exp_marker(i);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [NW*W-1:0] act,
                         input logic [NW*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard model
    logic [N*W-1:0] exp_q[$];
    logic [N*W-1:0] part_row;
    int             part_cnt = 0;
    int             data_rounds = 0;

    task automatic model_push(input logic [W-1:0] b);
        part_row[part_cnt*W +: W] = b;
        part_cnt++;
        if (part_cnt == N) begin
            exp_q.push_back(part_row);  // R1
            part_cnt = 0;
            data_rounds++;
            if (data_rounds == PER - 1) begin
                exp_q.push_back(marker_row());  // R4
                data_rounds = 0;
            end
        end
    endtask

    task automatic send(input logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_blk   = b;
        while (!in_ready) @(negedge clk);  // R5: held while stalled
        model_push(b);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_blk   = '1;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [W-1:0] mk_blk(input int k);
        logic [W-1:0] b;
        b[65:2] = {$urandom(), 32'(k)};
        b[1:0]  = (k % 5 == 0) ? 2'b10 : 2'b01;
        if (b[1:0] == 2'b10) b[9:2] = 8'h1E;  // control block, never the marker tag
        return b;
    endfunction

    // Monitor: pop and compare
    bit ready_low_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (lane_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected output", NW'(lane_blk), '0);
                end else begin
                    logic [N*W-1:0] e;
                    e = exp_q.pop_front();
                    check(lane_blk == e, "R1/R2/R3/R4 lane row", NW'(lane_blk), NW'(e));
                end
            end
            // R5: low ready <-> marker round on the next cycle
            check(ready_low_prev == (lane_valid && lane_blk == marker_row()),
                  "R5 stall vs marker", NW'(lane_valid), NW'(ready_low_prev));
        end
        ready_low_prev = !in_ready;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Wide instance: R7
    initial begin
        logic [NW*W-1:0] wexp;
        logic [NW*W-1:0] wrow;
        @(negedge clk); @(negedge clk); @(negedge clk);
        #1;
        @(negedge clk);
        for (int i = 0; i < NW; i++) wexp[i*W +: W] = exp_marker(i);
        check(w_lane_valid && w_lane_blk == wexp, "R7 20-lane markers", w_lane_blk, wexp);
        for (int k = 0; k < NW; k++) begin
            w_in_valid = 1'b1;
            w_in_blk   = mk_blk(1000 + k);
            wrow[k*W +: W] = w_in_blk;
            @(negedge clk);
            if (k < NW - 1) check(!w_lane_valid, "R8 20-lane partial", NW'(w_lane_valid), '0);
        end
        w_in_valid = 1'b0;
        check(w_lane_valid && w_lane_blk == wrow, "R7 20-lane data row", w_lane_blk, wrow);
        @(negedge clk);
        check(!w_lane_valid, "R2 single-cycle valid", NW'(w_lane_valid), '0);
    end

    initial begin
        exp_q.push_back(marker_row());  // R6: first marker after reset
        @(negedge clk);
        check(!lane_valid && !in_ready, "R6 reset state", NW'({lane_valid, in_ready}), '0);
        @(negedge clk);
        check(!lane_valid && !in_ready, "R6 reset state", NW'({lane_valid, in_ready}), '0);
        @(negedge clk);
        #1 rst_n = 1'b1;
        // back-to-back stream: period expiry meets round completion
        for (int k = 0; k < 40; k++) send(mk_blk(k));
        // partial round with a long gap: R8
        send(mk_blk(100));
        send(mk_blk(101));
        idle(6);
        for (int k = 0; k < 14; k++) send(mk_blk(200 + k));
        // sparse input
        for (int k = 0; k < 20; k++) begin
            send(mk_blk(300 + k));
            if (k % 3 == 0) idle(2);
        end
        // finish the open round if any
        while (part_cnt != 0) send(mk_blk(999));
        idle(1);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", NW'(exp_q.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule